// File: doc/BRIEF.md
# Four-Port GPIO Register Bank

This block is the register file behind four 8-bit general-purpose I/O ports. A host reaches it through a simple synchronous request bus. It issues at most one request per cycle and gets a registered response one cycle later. The response carries a ready strobe, an error flag and the read byte. Each port owns four registers: an output latch, an output-mode register, a direction register and a read-only pin-input register. Two pin-function select registers sit beside them.

The register offsets are spread sparsely over an 8-bit space. Offset bits [7:5] pick the register group. The low bits pick the port, with ports 0 to 3 at low offsets 0, 1, 4 and 5. Some registers implement only a few bits. A write that sets any bit a register does not implement is refused as a whole and answered with an error; the written bits are never trimmed to fit. The same error answer covers unmapped offsets, accesses wider than one byte and writes to an input register. A refused request never changes any state.

Each pin's output enable comes from the matching direction bit. Each pin's output value comes from the matching latch bit. The input registers show the external pins after a two-flop synchronizer.

Top module: `gpio_port_bank`

## Requirements
- R1: Offsets decode as follows. Latches are at 0x00, 0x01, 0x04, 0x05 for ports 0 to 3. Mode registers are at 0x20, 0x21, 0x24, 0x25. Direction registers are at 0x60, 0x61, 0x64, 0x65. Inputs are at 0x80, 0x81, 0x84, 0x85. Select A is at 0x44 and select B at 0x48. A legal write followed by a read of the same offset returns the written byte.
- R2: A request to any other offset gets rsp_error=1 and changes no register.
- R3: Only req_size=0 (one byte) is legal. Sizes 1, 2 and 3 (two, four and eight bytes) get rsp_error=1 and change no register.
- R4: After reset, every register reads 0x00, with two exceptions: the port 2 mode register reads 0xFF and select B reads 0x0F. pin_out and pin_oe are all zero after reset.
- R5: The port 3 latch, mode and direction registers implement bits [1:0] only. A write with any of bits [7:2] set gets an error and leaves the register unchanged.
- R6: The port 0 and port 1 mode registers implement bit 0 only. A write with any of bits [7:1] set gets an error and leaves the register unchanged.
- R7: Select A accepts a write only when bits [7:2] are zero. Select B accepts a write only when bits [7:4] are zero. Any other write gets an error and no change.
- R8: A write to any input register gets an error and has no effect.
- R9: An input register returns the port's pins delayed by two clock edges. A read sampled at the second edge after a pin change still returns the old value. Port 3 reads return 0 in bits [7:2].
- R10: pin_oe[8p+b] equals bit b of port p's direction register, where 1 means the pin drives. pin_out[8p+b] equals bit b of port p's latch.
- R11: rsp_ready is high exactly in the cycle after a request. rsp_rdata is zero on errors and on writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Register offset |
| req_size | input | 2 | Access size code, 0 = one byte |
| req_wdata | input | 8 | Write byte |
| rsp_ready | output | 1 | Response strobe, one cycle after the request |
| rsp_error | output | 1 | Request refused |
| rsp_rdata | output | 8 | Read byte |
| pin_in | input | 32 | External pin levels, port p on bits [8p+7:8p] |
| pin_out | output | 32 | Pin drive values |
| pin_oe | output | 32 | Pin output enables |

## Verification
The hardest case to reach from the ports is a pin change read back at exactly the second clock edge after it happens. At that edge the synchronizer has moved the new level only part of the way, so a read must still return the old value. The stimulus changes the pins on a falling edge and issues the read on the very next falling edge, expecting the stale byte. It then waits two more cycles and reads again, expecting the new byte. A refused write can also go unnoticed. Every refused write is therefore followed by a read of the same register, and the pin outputs are compared against the bench's own register model.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int PORTS    = 4;
  localparam int BYTE_W   = 8;
  localparam int OFFS_W   = 8;
  localparam int SIZE_W   = 2;
  localparam int SELECTS  = 2;
  localparam int PIN_W    = PORTS * BYTE_W;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_LATCH,
    RK_MODE,
    RK_SEL,
    RK_DIR,
    RK_PIN
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [1:0] idx;
  } reg_sel_t;

  // Offset bits [7:5] pick the group; the low bits pick the port.
  function automatic reg_sel_t decode_offset(input logic [OFFS_W-1:0] off);
    reg_sel_t s;
    logic     port_hit;
    logic [1:0] port;
    s = '{kind: RK_NONE, idx: 2'd0};
    port_hit = 1'b1;
    case (off[4:0])
      5'h00:   port = 2'd0;
      5'h01:   port = 2'd1;
      5'h04:   port = 2'd2;
      5'h05:   port = 2'd3;
      default: begin port = 2'd0; port_hit = 1'b0; end
    endcase
    case (off[7:5])
      3'd0: if (port_hit) s = '{kind: RK_LATCH, idx: port};
      3'd1: if (port_hit) s = '{kind: RK_MODE,  idx: port};
      3'd3: if (port_hit) s = '{kind: RK_DIR,   idx: port};
      3'd4: if (port_hit) s = '{kind: RK_PIN,   idx: port};
      3'd2: begin
        if (off[4:0] == 5'h04)      s = '{kind: RK_SEL, idx: 2'd0};
        else if (off[4:0] == 5'h08) s = '{kind: RK_SEL, idx: 2'd1};
      end
      default: s = '{kind: RK_NONE, idx: 2'd0};
    endcase
    return s;
  endfunction

  // Bits a register actually holds; a write outside them is refused.
  function automatic logic [BYTE_W-1:0] writable_mask(input reg_sel_t s);
    case (s.kind)
      RK_LATCH, RK_DIR: return (s.idx == 2'd3) ? 8'h03 : 8'hFF;
      RK_MODE: begin
        if (s.idx[1] == 1'b0) return 8'h01;
        return (s.idx == 2'd3) ? 8'h03 : 8'hFF;
      end
      RK_SEL:  return s.idx[0] ? 8'h0F : 8'h03;
      default: return 8'h00;
    endcase
  endfunction

  // Bits of a port that exist at all (port 3 has two pins).
  function automatic logic [BYTE_W-1:0] port_width_mask(input int p);
    return (p == 3) ? 8'h03 : 8'hFF;
  endfunction

  function automatic logic [BYTE_W-1:0] mode_reset(input int p);
    return (p == 2) ? 8'hFF : 8'h00;
  endfunction

  function automatic logic [BYTE_W-1:0] sel_reset(input int i);
    return (i == 1) ? 8'h0F : 8'h00;
  endfunction

endpackage

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode
  import gpio_bank_pkg::*;
(
  input  logic              req_write,
  input  logic [OFFS_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [BYTE_W-1:0] req_wdata,
  output reg_sel_t          acc_sel,
  output logic              acc_hit,
  output logic              acc_size_bad,
  output logic              acc_rsvd_bad,
  output logic              acc_err
);

  logic [BYTE_W-1:0] keep_mask;
  logic              ro_target;

  always_comb begin
    acc_sel      = decode_offset(req_addr);
    acc_hit      = (acc_sel.kind != RK_NONE);
    keep_mask    = writable_mask(acc_sel);
    ro_target    = (acc_sel.kind == RK_PIN);
    acc_size_bad = (req_size != '0);
    acc_rsvd_bad = req_write && !ro_target && ((req_wdata & ~keep_mask) != '0);
    acc_err      = !acc_hit || acc_size_bad || acc_rsvd_bad || (req_write && ro_target);
  end

endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic             warm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) warm_q <= 1'b0;
    else        warm_q <= 1'b1;
  end

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[0] <= '0;
          else        stage_q[0] <= async_in;
        end
        assert_first_stage_R9: assert property (@(posedge clk) disable iff (!rst_n)
          warm_q |-> stage_q[0] == $past(async_in));
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
        assert_stage_shift_R9: assert property (@(posedge clk) disable iff (!rst_n)
          warm_q |-> stage_q[s] == $past(stage_q[s-1]));
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
  import gpio_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [7:0]        req_addr,
  input  logic [1:0]        req_size,
  input  logic [7:0]        req_wdata,
  output logic              rsp_ready,
  output logic              rsp_error,
  output logic [7:0]        rsp_rdata,
  input  logic [31:0]       pin_in,
  output logic [31:0]       pin_out,
  output logic [31:0]       pin_oe
);

  localparam int STATE_W = (3 * PORTS + SELECTS) * BYTE_W;

  logic [BYTE_W-1:0] latch_q [PORTS];
  logic [BYTE_W-1:0] mode_q  [PORTS];
  logic [BYTE_W-1:0] dir_q   [PORTS];
  logic [BYTE_W-1:0] sel_q   [SELECTS];
  logic [BYTE_W-1:0] pin_rd  [PORTS];
  logic [PIN_W-1:0]  pin_sync;

  reg_sel_t          acc_sel;
  logic              acc_hit, acc_size_bad, acc_rsvd_bad, acc_err;
  logic              wr_fire, rd_fire;
  logic [BYTE_W-1:0] rd_byte;
  logic [STATE_W-1:0] state_flat;

  gpio_bank_decode u_decode (
    .req_write    (req_write),
    .req_addr     (req_addr),
    .req_size     (req_size),
    .req_wdata    (req_wdata),
    .acc_sel      (acc_sel),
    .acc_hit      (acc_hit),
    .acc_size_bad (acc_size_bad),
    .acc_rsvd_bad (acc_rsvd_bad),
    .acc_err      (acc_err)
  );

  gpio_pin_sync #(.WIDTH(PIN_W), .STAGES(2)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .sync_out (pin_sync)
  );

  assign wr_fire = req_valid && req_write && !acc_err;
  assign rd_fire = req_valid && !req_write && !acc_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < PORTS; p++) begin
        latch_q[p] <= '0;
        mode_q[p]  <= mode_reset(p);
        dir_q[p]   <= '0;
      end
      for (int i = 0; i < SELECTS; i++) sel_q[i] <= sel_reset(i);
    end else if (wr_fire) begin
      case (acc_sel.kind)
        RK_LATCH: latch_q[acc_sel.idx]  <= req_wdata;
        RK_MODE:  mode_q[acc_sel.idx]   <= req_wdata;
        RK_DIR:   dir_q[acc_sel.idx]    <= req_wdata;
        RK_SEL:   sel_q[acc_sel.idx[0]] <= req_wdata;
        default:  ;
      endcase
    end
  end

  genvar gp;
  generate
    for (gp = 0; gp < PORTS; gp++) begin : g_port
      assign pin_rd[gp] = pin_sync[gp*BYTE_W +: BYTE_W] & port_width_mask(gp);
      assign pin_out[gp*BYTE_W +: BYTE_W] = latch_q[gp];
      assign pin_oe[gp*BYTE_W +: BYTE_W]  = dir_q[gp];
      assign state_flat[(3*gp)*BYTE_W +: BYTE_W]   = latch_q[gp];
      assign state_flat[(3*gp+1)*BYTE_W +: BYTE_W] = mode_q[gp];
      assign state_flat[(3*gp+2)*BYTE_W +: BYTE_W] = dir_q[gp];
    end
    for (gp = 0; gp < SELECTS; gp++) begin : g_selflat
      assign state_flat[(3*PORTS+gp)*BYTE_W +: BYTE_W] = sel_q[gp];
    end
  endgenerate

  always_comb begin
    case (acc_sel.kind)
      RK_LATCH: rd_byte = latch_q[acc_sel.idx];
      RK_MODE:  rd_byte = mode_q[acc_sel.idx];
      RK_DIR:   rd_byte = dir_q[acc_sel.idx];
      RK_PIN:   rd_byte = pin_rd[acc_sel.idx];
      RK_SEL:   rd_byte = sel_q[acc_sel.idx[0]];
      default:  rd_byte = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_ready <= 1'b0;
      rsp_error <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_ready <= req_valid;
      rsp_error <= req_valid && acc_err;
      rsp_rdata <= rd_fire ? rd_byte : '0;
    end
  end

  // Assertions
  assert_rsp_follows_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_ready);
  assert_no_spurious_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_ready);
  assert_err_data_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_error |-> (rsp_rdata == '0 && rsp_ready));
  assert_unmapped_keeps_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !acc_hit) |=> (rsp_error && $stable(state_flat)));
  assert_size_keeps_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && acc_size_bad) |=> (rsp_error && $stable(state_flat)));
  assert_reserved_rejected_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && acc_rsvd_bad) |=> (rsp_error && $stable(state_flat)));
  assert_pin_write_rejected_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr[7:5] == 3'd4) |=> (rsp_error && $stable(state_flat)));
  assert_port3_narrow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out[31:26] == '0 && pin_oe[31:26] == '0 && mode_q[3][7:2] == '0));
  assert_mode01_narrow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[0][7:1] == '0 && mode_q[1][7:1] == '0));

endmodule

// File: tb/gpio_port_bank_test.sv
module gpio_port_bank_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_ready, rsp_error;
  logic [7:0]  rsp_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  gpio_port_bank uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_ready(rsp_ready), .rsp_error(rsp_error), .rsp_rdata(rsp_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  always #5 clk = ~clk;

  // Bench model: codes 0-3 latch, 4-7 mode, 8-11 dir, 12-15 input, 16-17 select.
  logic [7:0] model [18];
  logic [31:0] pins_seen = '0;

  bit         q_err  [$];
  logic [7:0] q_data [$];
  string      q_tag  [$];

  function automatic int where(input logic [7:0] a);
    case (a)
      8'h00: return 0;   8'h01: return 1;   8'h04: return 2;   8'h05: return 3;
      8'h20: return 4;   8'h21: return 5;   8'h24: return 6;   8'h25: return 7;
      8'h60: return 8;   8'h61: return 9;   8'h64: return 10;  8'h65: return 11;
      8'h80: return 12;  8'h81: return 13;  8'h84: return 14;  8'h85: return 15;
      8'h44: return 16;  8'h48: return 17;
      default: return -1;
    endcase
  endfunction

  function automatic logic [7:0] legal_bits(input int c);
    if (c == 16) return 8'h03;
    if (c == 17) return 8'h0F;
    if (c == 4 || c == 5) return 8'h01;
    if (c == 3 || c == 7 || c == 11) return 8'h03;
    return 8'hFF;
  endfunction

  function automatic logic [7:0] model_read(input int c);
    if (c >= 12 && c <= 15) begin
      if (c == 15) return {6'b0, pins_seen[25:24]};
      return pins_seen[(c-12)*8 +: 8];
    end
    return model[c];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [7:0] a, input logic [1:0] sz,
                        input logic [7:0] d, input string tag);
    int c;
    bit e;
    logic [7:0] rd;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = d;
    c = where(a);
    e = (c < 0) || (sz != 2'd0);
    if (!e && wr) e = (c >= 12 && c <= 15) || ((d & ~legal_bits(c)) != 8'h00);
    rd = (!e && !wr) ? model_read(c) : 8'h00;
    if (!e && wr) model[c] = d;
    q_err.push_back(e); q_data.push_back(rd); q_tag.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    access(1'b0, a, 2'd0, 8'h00, tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input string tag);
    access(1'b1, a, 2'd0, d, tag);
  endtask

  function automatic logic [31:0] model_pins(input int base);
    return {model[base+3], model[base+2], model[base+1], model[base]};
  endfunction

  // Monitor: pops the expected item for each response.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rsp_ready) begin
        if (q_err.size() == 0) begin
          check("R11 unexpected response", 32'd1, 32'd0);
        end else begin
          bit e; logic [7:0] d; string t;
          e = q_err.pop_front(); d = q_data.pop_front(); t = q_tag.pop_front();
          check({t, " error"}, {31'd0, rsp_error}, {31'd0, e});
          check({t, " data"}, {24'd0, rsp_rdata}, {24'd0, d});
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        mismatched++;
        $display("FAIL watchdog: actual %0d expected < 100000 cycles", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
      end
    end
  end

  initial begin
    for (int i = 0; i < 18; i++) model[i] = 8'h00;
    model[6]  = 8'hFF;
    model[17] = 8'h0F;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R4: reset state
    check("R4 pin_out reset", pin_out, 32'h0);
    check("R4 pin_oe reset", pin_oe, 32'h0);
    check("R11 idle ready", {31'd0, rsp_ready}, 32'd0);
    foreach (model[i]) ;
    begin
      logic [7:0] offs [18] = '{8'h00,8'h01,8'h04,8'h05,8'h20,8'h21,8'h24,8'h25,
                                8'h60,8'h61,8'h64,8'h65,8'h80,8'h81,8'h84,8'h85,8'h44,8'h48};
      for (int i = 0; i < 18; i++) rd(offs[i], "R4 reset read");

      // R1: write then read back every writable register
      wr(8'h00, 8'hA5, "R1 latch0");  wr(8'h01, 8'h3C, "R1 latch1");
      wr(8'h04, 8'hF0, "R1 latch2");  wr(8'h05, 8'h02, "R1 latch3");
      wr(8'h20, 8'h01, "R1 mode0");   wr(8'h21, 8'h01, "R1 mode1");
      wr(8'h24, 8'h5A, "R1 mode2");   wr(8'h25, 8'h03, "R1 mode3");
      wr(8'h60, 8'h0F, "R1 dir0");    wr(8'h61, 8'hFF, "R1 dir1");
      wr(8'h64, 8'h81, "R1 dir2");    wr(8'h65, 8'h01, "R1 dir3");
      wr(8'h44, 8'h02, "R7 selA ok"); wr(8'h48, 8'h09, "R7 selB ok");
      for (int i = 0; i < 18; i++) if (i < 12 || i > 15) rd(offs[i], "R1 readback");

      // R10: pins follow latch and direction
      check("R10 pin_out", pin_out, model_pins(0));
      check("R10 pin_oe", pin_oe, model_pins(8));

      // R2: unmapped offsets
      access(1'b1, 8'h02, 2'd0, 8'h11, "R2 unmapped write");
      access(1'b1, 8'h45, 2'd0, 8'h01, "R2 unmapped write sel gap");
      access(1'b0, 8'hFF, 2'd0, 8'h00, "R2 unmapped read");
      access(1'b1, 8'hA0, 2'd0, 8'h01, "R2 unmapped group");
      rd(8'h00, "R2 latch0 intact");

      // R3: wider sizes
      access(1'b1, 8'h00, 2'd1, 8'h00, "R3 half write");
      access(1'b1, 8'h60, 2'd2, 8'h00, "R3 word write");
      access(1'b0, 8'h24, 2'd3, 8'h00, "R3 dword read");
      rd(8'h00, "R3 latch0 intact"); rd(8'h60, "R3 dir0 intact");

      // R5: port 3 narrow registers
      wr(8'h05, 8'h04, "R5 latch3 bit2");
      wr(8'h25, 8'h80, "R5 mode3 bit7");
      wr(8'h65, 8'hFF, "R5 dir3 all");
      wr(8'h65, 8'h03, "R5 dir3 legal");
      rd(8'h05, "R5 latch3 kept"); rd(8'h25, "R5 mode3 kept"); rd(8'h65, "R5 dir3");

      // R6: port 0/1 mode bit 0 only
      wr(8'h20, 8'h02, "R6 mode0 bit1");
      wr(8'h21, 8'hFF, "R6 mode1 all");
      wr(8'h20, 8'h00, "R6 mode0 clear");
      rd(8'h20, "R6 mode0"); rd(8'h21, "R6 mode1 kept");

      // R7: select masks
      wr(8'h44, 8'h04, "R7 selA bit2");
      wr(8'h48, 8'h10, "R7 selB bit4");
      wr(8'h48, 8'h0F, "R7 selB full");
      rd(8'h44, "R7 selA kept"); rd(8'h48, "R7 selB");

      // R8: inputs read-only
      wr(8'h80, 8'h00, "R8 in0 write");
      wr(8'h85, 8'h01, "R8 in3 write");
      check("R10 pin_out after rejects", pin_out, model_pins(0));
      check("R10 pin_oe after rejects", pin_oe, model_pins(8));
    end

    // R9: synchronizer depth; stale at the second edge, fresh after
    @(negedge clk);
    pin_in = 32'hFFC3_7E18;
    rd(8'h81, "R9 stale at second edge");
    pins_seen = pin_in;
    repeat (2) @(negedge clk);
    rd(8'h80, "R9 in0"); rd(8'h81, "R9 in1"); rd(8'h84, "R9 in2");
    rd(8'h85, "R9 in3 upper zero");
    @(negedge clk);
    pin_in = 32'h0255_AA01;
    repeat (3) @(negedge clk);
    pins_seen = pin_in;
    rd(8'h84, "R9 in2 new"); rd(8'h85, "R9 in3 new");

    repeat (3) @(negedge clk);
    check("R11 queue drained", q_err.size(), 32'd0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule